// File: doc/BRIEF.md
# Return-Address Stack with Fill-Level Interrupt

This block is a synchronous last-in first-out store that holds return addresses for a program sequencer across calls, loops and interrupt entry. The sequencer drives a push strobe with a data word and a pop strobe. The block keeps a fill count and returns popped words one cycle after the pop strobe. Simultaneous push and pop swaps the top word for the new one. The default depth is 33 words of 24 bits. Parameters let the same module serve as a smaller loop-state stack, for example 8 deep.

A level-sensitive interrupt request warns software before the stack runs out in either direction. The request is raised while the occupancy is below a low mark (default 3) or above a high mark (default 28), and it is gated by an enable input that comes from a bit of the interrupt control register. A handler can then spill words to memory or refill them in time. Pushing into a full stack or popping an empty one is recorded in sticky error flags that only reset clears.

Top module: `hw_stack`

## Requirements
- R1: After reset the fill level is 0, `isEmpty` is 1, `isFull` is 0, both sticky flags are 0 and `popData` is 0.
- R2: A push alone on a non-full stack stores `pushData` and raises the level by one. A pop alone on a non-empty stack lowers the level by one, and on the next cycle `popData` holds the most recently pushed remaining word (LIFO order).
- R3: A push alone on a full stack (level = DEPTH) discards the data, leaves the level and contents unchanged and sets `overflowErr`, which stays 1 until reset.
- R4: A pop alone on an empty stack leaves the level at 0, drives `popData` to 0 on the next cycle and sets `underflowErr`, which stays 1 until reset.
- R5: Push and pop together on a non-empty stack (full included) return the old top word on `popData` the next cycle, replace it with `pushData`, leave the level unchanged and set no flag.
- R6: Push and pop together on an empty stack store `pushData` (level becomes 1), return 0 on `popData` and set `underflowErr`.
- R7: `irqReq` is 1 when `irqEnable` is 1 and the level is below LOW_MARK (default: level 0, 1 or 2). It follows the level in the same cycle the level register updates.
- R8: `irqReq` is 1 when `irqEnable` is 1 and the level is above HIGH_MARK (default: level 29 to 33).
- R9: `irqReq` is 0 for levels from LOW_MARK to HIGH_MARK inclusive, and it is 0 at every level while `irqEnable` is 0.
- R10: `isFull` is 1 exactly when the level equals DEPTH, and `isEmpty` is 1 exactly when the level is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| pushEn | input | 1 | Push strobe |
| popEn | input | 1 | Pop strobe |
| pushData | input | 24 | Word to push |
| irqEnable | input | 1 | Stack-level interrupt enable |
| popData | output | 24 | Popped word, valid the cycle after a pop |
| level | output | 6 | Current occupancy |
| isFull | output | 1 | Occupancy equals depth |
| isEmpty | output | 1 | Occupancy is zero |
| irqReq | output | 1 | Watermark interrupt request |
| overflowErr | output | 1 | Sticky push-on-full flag |
| underflowErr | output | 1 | Sticky pop-on-empty flag |

## Verification
A corrupted fill counter shows up at the ports in the same cycle as a wrong `level`, `isFull`/`isEmpty` or `irqReq`. The same fault shows up one cycle after the next pop as a word out of LIFO order. A wrong write or read index leaves the level correct and shows only when that slot is popped, possibly many cycles later. For that reason the stack is filled to the top and drained completely, and each popped word is compared against a scoreboard. The error flags are checked at every step, because one missed or spurious set persists until reset.

// File: rtl/stack_pkg.sv
package stack_pkg;
  // Strobes from the control half to the storage half.
  typedef struct packed {
    logic wrNew;   // write at slot 'level' (grows)
    logic wrTop;   // overwrite slot 'level-1'
    logic rdTop;   // capture slot 'level-1' into popData
    logic rdZero;  // capture zero into popData
  } stackStrobes_t;
endpackage

// File: rtl/stack_ctrl.sv
module stack_ctrl
  import stack_pkg::*;
#(
  parameter int DEPTH     = 33,
  parameter int LOW_MARK  = 3,
  parameter int HIGH_MARK = 28,
  localparam int LVL_W    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pushEn,
  input  logic             popEn,
  input  logic             irqEnable,
  output stackStrobes_t    strb,
  output logic [LVL_W-1:0] level,
  output logic             isFull,
  output logic             isEmpty,
  output logic             irqReq,
  output logic             overflowErr,
  output logic             underflowErr
);
  localparam logic [LVL_W-1:0] DEPTH_L = LVL_W'(DEPTH);
  localparam logic [LVL_W-1:0] LOW_L   = LVL_W'(LOW_MARK);
  localparam logic [LVL_W-1:0] HIGH_L  = LVL_W'(HIGH_MARK);

  logic incr, decr, setOvf, setUnf;

  assign isEmpty = (level == '0);
  assign isFull  = (level == DEPTH_L);

  always_comb begin
    strb   = '0;
    incr   = 1'b0;
    decr   = 1'b0;
    setOvf = 1'b0;
    setUnf = 1'b0;
    if (pushEn && popEn) begin
      if (isEmpty) begin
        strb.wrNew  = 1'b1;
        strb.rdZero = 1'b1;
        incr        = 1'b1;
        setUnf      = 1'b1;
      end else begin
        strb.wrTop = 1'b1;
        strb.rdTop = 1'b1;
      end
    end else if (pushEn) begin
      if (isFull) setOvf = 1'b1;
      else begin
        strb.wrNew = 1'b1;
        incr       = 1'b1;
      end
    end else if (popEn) begin
      if (isEmpty) begin
        strb.rdZero = 1'b1;
        setUnf      = 1'b1;
      end else begin
        strb.rdTop = 1'b1;
        decr       = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      level        <= '0;
      overflowErr  <= 1'b0;
      underflowErr <= 1'b0;
    end else begin
      if (incr)        level <= level + 1'b1;
      else if (decr)   level <= level - 1'b1;
      if (setOvf) overflowErr  <= 1'b1;
      if (setUnf) underflowErr <= 1'b1;
    end
  end

  assign irqReq = irqEnable && ((level < LOW_L) || (level > HIGH_L));

  // R10: occupancy never exceeds the depth
  assert_level_bound_R10: assert property (@(posedge clk) disable iff (!rstN)
    level <= DEPTH_L);
  // R3: push into a full stack holds the level and flags overflow
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rstN)
    (pushEn && !popEn && isFull) |=> (isFull && overflowErr));
  // R3: overflow flag is sticky
  assert_ovf_sticky_R3: assert property (@(posedge clk) disable iff (!rstN)
    overflowErr |=> overflowErr);
  // R4: pop from an empty stack flags underflow and stays empty
  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rstN)
    (popEn && !pushEn && isEmpty) |=> (isEmpty && underflowErr));
  // R4: underflow flag is sticky
  assert_unf_sticky_R4: assert property (@(posedge clk) disable iff (!rstN)
    underflowErr |=> underflowErr);
  // R5: swap on a non-empty stack keeps the level
  assert_swap_level_R5: assert property (@(posedge clk) disable iff (!rstN)
    (pushEn && popEn && !isEmpty) |=> $stable(level));
  // R2: a lone push on a non-full stack grows the level by one
  assert_push_grow_R2: assert property (@(posedge clk) disable iff (!rstN)
    (pushEn && !popEn && !isFull) |=> (level == $past(level) + 1'b1));
endmodule

// File: rtl/stack_dp.sv
module stack_dp
  import stack_pkg::*;
#(
  parameter int DEPTH    = 33,
  parameter int WIDTH    = 24,
  localparam int LVL_W   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  stackStrobes_t    strb,
  input  logic [LVL_W-1:0] level,
  input  logic [WIDTH-1:0] pushData,
  output logic [WIDTH-1:0] popData
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [LVL_W-1:0] topIdx;

  assign topIdx = level - 1'b1;

  always_ff @(posedge clk) begin
    if (strb.wrNew) mem[level]  <= pushData;
    if (strb.wrTop) mem[topIdx] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN)            popData <= '0;
    else if (strb.rdZero) popData <= '0;
    else if (strb.rdTop)  popData <= mem[topIdx];
  end

  // R4: a pop with nothing stored returns zero
  assert_zero_on_empty_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdZero |=> (popData == '0));
  // R2: write and read strobes never target an empty slot for reading
  assert_read_valid_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdTop |-> (level != '0));
endmodule

// File: rtl/hw_stack.sv
module hw_stack
  import stack_pkg::*;
#(
  parameter int DEPTH     = 33,
  parameter int WIDTH     = 24,
  parameter int LOW_MARK  = 3,
  parameter int HIGH_MARK = 28,
  localparam int LVL_W    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pushEn,
  input  logic             popEn,
  input  logic [WIDTH-1:0] pushData,
  input  logic             irqEnable,
  output logic [WIDTH-1:0] popData,
  output logic [LVL_W-1:0] level,
  output logic             isFull,
  output logic             isEmpty,
  output logic             irqReq,
  output logic             overflowErr,
  output logic             underflowErr
);
  stackStrobes_t strb;

  stack_ctrl #(.DEPTH(DEPTH), .LOW_MARK(LOW_MARK), .HIGH_MARK(HIGH_MARK)) u_ctrl (
    .clk(clk), .rstN(rstN), .pushEn(pushEn), .popEn(popEn),
    .irqEnable(irqEnable), .strb(strb), .level(level), .isFull(isFull),
    .isEmpty(isEmpty), .irqReq(irqReq), .overflowErr(overflowErr),
    .underflowErr(underflowErr)
  );

  stack_dp #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .level(level),
    .pushData(pushData), .popData(popData)
  );
endmodule

// File: tb/sim_hw_stack.sv
module sim_hw_stack;
  localparam int DEPTH = 33;
  localparam int WIDTH = 24;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pushEn = 1'b0, popEn = 1'b0, irqEnable = 1'b1;
  logic [WIDTH-1:0] pushData = '0;
  logic [WIDTH-1:0] popData;
  logic [5:0] level;
  logic isFull, isEmpty, irqReq, overflowErr, underflowErr;

  hw_stack u0 (
    .clk(clk), .rstN(rstN), .pushEn(pushEn), .popEn(popEn),
    .pushData(pushData), .irqEnable(irqEnable), .popData(popData),
    .level(level), .isFull(isFull), .isEmpty(isEmpty), .irqReq(irqReq),
    .overflowErr(overflowErr), .underflowErr(underflowErr)
  );

  always #5 clk = ~clk;

  int nChecks = 0;
  int nFail = 0;
  int model[$];
  int expQ[$];
  string tagQ[$];
  bit mOvf = 0, mUnf = 0;

  task automatic chk(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Monitor: compares popped words against the scoreboard.
  always @(posedge clk) begin
    #2;
    if (expQ.size() > 0) chk(tagQ.pop_front(), int'(popData), expQ.pop_front());
  end

  function automatic int expIrq(int lvl);
    return (irqEnable && (lvl < 3 || lvl > 28)) ? 1 : 0;
  endfunction

  task automatic checkState(string req);
    int lvl = model.size();
    chk({req, " level"}, int'(level), lvl);
    chk("R10 full", int'(isFull), (lvl == DEPTH) ? 1 : 0);
    chk("R10 empty", int'(isEmpty), (lvl == 0) ? 1 : 0);
    chk(lvl < 3 ? "R7 irq" : (lvl > 28 ? "R8 irq" : "R9 irq"), int'(irqReq), expIrq(lvl));
    chk("R3 ovf", int'(overflowErr), int'(mOvf));
    chk("R4 unf", int'(underflowErr), int'(mUnf));
  endtask

  // Driver: applies one operation, updates the model and scoreboard.
  task automatic step(bit doPush, bit doPop, int data, string req);
    int exp = 0;
    @(negedge clk);
    pushEn = doPush; popEn = doPop; pushData = WIDTH'(data);
    @(posedge clk);
    if (doPush && doPop) begin
      if (model.size() == 0) begin mUnf = 1; model.push_back(data); end
      else begin exp = model[$]; model[$] = data; end
    end else if (doPush) begin
      if (model.size() == DEPTH) mOvf = 1; else model.push_back(data);
    end else if (doPop) begin
      if (model.size() == 0) mUnf = 1; else exp = model.pop_back();
    end
    if (doPop) begin expQ.push_back(exp); tagQ.push_back({req, " popData"}); end
    @(negedge clk);
    pushEn = 0; popEn = 0;
    checkState(req);
  endtask

  initial begin
    #2_000_000;
    nChecks++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 popData", int'(popData), 0);
    checkState("R1");
    rstN = 1'b1;
    // R2: short LIFO run
    step(1, 0, 'h111, "R2");
    step(1, 0, 'h222, "R2");
    step(0, 1, 0, "R2");
    step(0, 1, 0, "R2");
    // R4: pop on empty, flag stays set
    step(0, 1, 0, "R4");
    step(0, 0, 0, "R4");
    // R6: swap on empty
    step(1, 1, 'h5A5A5A, "R6");
    // R5: swap on non-empty
    step(1, 1, 'hABCDEF, "R5");
    // fill to the top, checking watermarks at every level (R7, R8, R9)
    for (int i = 0; i < DEPTH - 1; i++) step(1, 0, 'h10000 + i * 7, "R2");
    // R3: push on full discarded
    step(1, 0, 'hFFFFFF, "R3");
    step(0, 0, 0, "R3");
    // R5: swap on full
    step(1, 1, 'h0C0FFE, "R5");
    // R9: enable low masks the request at a high level
    irqEnable = 1'b0;
    step(0, 0, 0, "R9");
    irqEnable = 1'b1;
    // R2: drain, checking LIFO order and watermarks
    for (int i = 0; i < DEPTH; i++) step(0, 1, 0, "R2");
    step(0, 1, 0, "R4");
    irqEnable = 1'b0;
    step(0, 0, 0, "R9");
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule